// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block puts a small set of byte-wide configuration registers behind just two I/O addresses. Software first writes the number of the register it wants to the even address of the pair. It then reads or writes the register's contents through the odd address. Each access to the data address consumes the selection and returns the held index to zero, so every data access must be preceded by its own index write. Only eight index values name real registers: 0x01 and the run 0x70 to 0x76. Any other index value is refused when written.

A refused index write leaves the previous selection in place. A data write made while no register is selected is dropped. A data read made while no register is selected returns all ones, and neither of these consumes the selection. The bus is a single-cycle strobe interface. Read data is captured into a register and appears one cycle after the read strobe, then holds until the next read that hits the pair.

Internally, a two-state selection machine tracks whether a register is selected. In state IDX_CLEAR the held index is zero. An accepted index write moves it to IDX_ARMED (transition *arm*). In IDX_ARMED, an accepted index write reloads the index and the machine stays in IDX_ARMED (transition *rearm*). A data read or data write returns the machine to IDX_CLEAR (transition *consume*). Any other stimulus holds the current state.

Top module: `cfg_idx_port`

## Requirements
- R1: The index port is I/O address 0x0022 and the data port is 0x0023; all 16 address bits are compared, bit 0 selects data (1) or index (0). A strobe at any other address changes neither the held index, nor any register, nor bus_rdata.
- R2: An index write of 0x01 or of a value in 0x70..0x76 loads that value as the held index; an index write of any other value leaves the held index unchanged.
- R3: A read of the index port returns the held index as it was before the read, and does not change it; after reset the held index is 0x00.
- R4: A data write while a valid index is held stores the full write byte into the selected register, changes no other register, and clears the held index to 0x00.
- R5: A data read while a valid index is held returns the selected register's contents and clears the held index to 0x00.
- R6: While no valid index is held, a data write is ignored (no register changes), and a data read returns 0xFF; neither changes the held index.
- R7: Reset (synchronous, active high) sets register 0x01 to 0xC0, 0x71 to 0x01, 0x72 to 0xFF, and registers 0x70, 0x73, 0x74, 0x75 and 0x76 to 0x00; bus_rdata resets to 0x00.
- R8: bus_rdata is registered: it shows the result of a read one cycle after the read strobe and holds its value in every cycle without a read hitting the pair.
- R9: When write and read strobes are both high in one cycle, only the write is performed; bus_rdata does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address of the current access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |

## Verification
The awkward case is a data access with no valid selection. Since refused index writes keep the old index, the only way into that case is the IDX_CLEAR state. The stimulus reaches it by consuming a selection first, and then issues a data write followed by a data read. It then reads every register back to show nothing moved. A second subtle case is an address that differs from the pair only above bit 0's neighbours (0x0122/0x0123). It is driven with a valid index already held, so any aliasing would both overwrite a register and consume the index, visibly.

// File: rtl/cfg_idx_pkg.sv
package cfg_idx_pkg;

    // Selection machine states
    typedef enum logic {
        IDX_CLEAR,
        IDX_ARMED
    } idx_state_e;

    // Decoded bus operation for one cycle
    typedef enum logic [2:0] {
        OP_NONE,
        OP_IDX_WR,
        OP_IDX_RD,
        OP_DAT_WR,
        OP_DAT_RD
    } bus_op_e;

    // Power-on contents of each register, by register index
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            'h01:    return 8'hC0;
            'h71:    return 8'h01;
            'h72:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_idx_decode.sv
module cfg_idx_decode
    import cfg_idx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 'h22
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output bus_op_e           op_o
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

    logic pair_hit;
    assign pair_hit = (addr_i[ADDR_W-1:1] == BASE_V[ADDR_W-1:1]);

    // Write wins over read when both strobes are present
    always_comb begin
        op_o = OP_NONE;
        if (pair_hit) begin
            if (wr_i) begin
                if (addr_i[0]) op_o = OP_DAT_WR;
                else           op_o = OP_IDX_WR;
            end else if (rd_i) begin
                if (addr_i[0]) op_o = OP_DAT_RD;
                else           op_o = OP_IDX_RD;
            end
        end
    end
endmodule

// File: rtl/cfg_idx_slot.sv
module cfg_idx_slot #(
    parameter int DATA_W   = 8,
    parameter int LO_IDX   = 'h01,
    parameter int HI_BASE  = 'h70,
    parameter int HI_COUNT = 7,
    parameter int SLOT_W   = 3
) (
    input  logic [DATA_W-1:0] idx_i,
    output logic              valid_o,
    output logic [SLOT_W-1:0] slot_o
);
    localparam logic [DATA_W-1:0] LO_V  = DATA_W'(LO_IDX);
    localparam logic [DATA_W-1:0] HI_V  = DATA_W'(HI_BASE);
    localparam logic [DATA_W-1:0] CNT_V = DATA_W'(HI_COUNT);

    logic [DATA_W-1:0] off;
    logic              in_hi;

    assign off   = idx_i - HI_V;
    assign in_hi = (idx_i >= HI_V) && (off < CNT_V);

    // Slot 0 is the lone low register, slots 1.. are the contiguous run
    always_comb begin
        if (idx_i == LO_V) begin
            valid_o = 1'b1;
            slot_o  = '0;
        end else if (in_hi) begin
            valid_o = 1'b1;
            slot_o  = off[SLOT_W-1:0] + SLOT_W'(1);
        end else begin
            valid_o = 1'b0;
            slot_o  = '0;
        end
    end
endmodule

// File: rtl/cfg_idx_fsm.sv
module cfg_idx_fsm
    import cfg_idx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_e           op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cand_valid_i,
    input  logic [SLOT_W-1:0] cand_slot_i,
    output logic [DATA_W-1:0] idx_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic              armed_o
);
    idx_state_e        state_q, state_d;
    logic [DATA_W-1:0] idx_d;
    logic [SLOT_W-1:0] slot_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IDX_CLEAR;
            idx_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            slot_q  <= slot_d;
        end
    end

    // Transitions: arm, rearm, consume
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        slot_d  = slot_q;
        unique case (state_q)
            IDX_CLEAR: begin
                if (op_i == OP_IDX_WR && cand_valid_i) begin
                    state_d = IDX_ARMED;
                    idx_d   = wdata_i;
                    slot_d  = cand_slot_i;
                end
            end
            IDX_ARMED: begin
                if (op_i == OP_IDX_WR && cand_valid_i) begin
                    idx_d  = wdata_i;
                    slot_d = cand_slot_i;
                end else if (op_i == OP_DAT_WR || op_i == OP_DAT_RD) begin
                    state_d = IDX_CLEAR;
                    idx_d   = '0;
                    slot_d  = '0;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        armed_o = (state_q == IDX_ARMED);
    end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_idx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3,
    parameter int LO_IDX    = 'h01,
    parameter int HI_BASE   = 'h70
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we_i,
    input  logic [SLOT_W-1:0]                slot_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_o
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int               REG_IDX = (s == 0) ? LO_IDX : HI_BASE + s - 1;
        localparam logic [DATA_W-1:0] DEF    = DATA_W'(reg_default(REG_IDX));

        logic [DATA_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= DEF;
            else if (we_i && slot_i == SLOT_W'(s))
                q <= wdata_i;
        end

        assign regs_o[s] = q;
    end
endmodule

// File: rtl/cfg_idx_port.sv
module cfg_idx_port
    import cfg_idx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 'h22,
    parameter int LO_IDX    = 'h01,
    parameter int HI_BASE   = 'h70,
    parameter int HI_COUNT  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int NUM_SLOTS = HI_COUNT + 1;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    bus_op_e                          op;
    logic                             cand_valid;
    logic [SLOT_W-1:0]                cand_slot;
    logic [DATA_W-1:0]                idx_q;
    logic [SLOT_W-1:0]                slot_q;
    logic                             armed;
    logic                             bank_we;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_q;

    cfg_idx_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) decode_i (
        .addr_i(bus_addr),
        .wr_i  (bus_wr),
        .rd_i  (bus_rd),
        .op_o  (op)
    );

    cfg_idx_slot #(
        .DATA_W  (DATA_W),
        .LO_IDX  (LO_IDX),
        .HI_BASE (HI_BASE),
        .HI_COUNT(HI_COUNT),
        .SLOT_W  (SLOT_W)
    ) slot_i (
        .idx_i  (bus_wdata),
        .valid_o(cand_valid),
        .slot_o (cand_slot)
    );

    cfg_idx_fsm #(
        .DATA_W(DATA_W),
        .SLOT_W(SLOT_W)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op),
        .wdata_i     (bus_wdata),
        .cand_valid_i(cand_valid),
        .cand_slot_i (cand_slot),
        .idx_q       (idx_q),
        .slot_q      (slot_q),
        .armed_o     (armed)
    );

    assign bank_we = (op == OP_DAT_WR) && armed;

    cfg_reg_bank #(
        .DATA_W   (DATA_W),
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W),
        .LO_IDX   (LO_IDX),
        .HI_BASE  (HI_BASE)
    ) bank_i (
        .clk    (clk),
        .rst    (rst),
        .we_i   (bank_we),
        .slot_i (slot_q),
        .wdata_i(bus_wdata),
        .regs_o (regs_q)
    );

    // Registered read-back
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            unique case (op)
                OP_IDX_RD: bus_rdata <= idx_q;
                OP_DAT_RD: bus_rdata <= armed ? regs_q[slot_q] : '1;
                default:   bus_rdata <= bus_rdata;
            endcase
        end
    end
endmodule

// File: rtl/cfg_idx_port_chk.sv
module cfg_idx_port_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int BASE_ADDR = 'h22,
    parameter int LO_IDX    = 'h01,
    parameter int HI_BASE   = 'h70,
    parameter int HI_COUNT  = 7
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic [ADDR_W-1:0]                     bus_addr,
    input logic [DATA_W-1:0]                     bus_wdata,
    input logic                                  bus_wr,
    input logic                                  bus_rd,
    input logic [DATA_W-1:0]                     bus_rdata,
    input logic [DATA_W-1:0]                     idx_q,
    input logic [(HI_COUNT+1)*DATA_W-1:0]        regs_flat
);
    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_ADDR) & ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] DAT_A = IDX_A | ADDR_W'(1);

    function automatic logic idx_ok(input logic [DATA_W-1:0] v);
        return (v == DATA_W'(LO_IDX)) ||
               (v >= DATA_W'(HI_BASE) && v < DATA_W'(HI_BASE + HI_COUNT));
    endfunction

    logic in_pair, idx_wr, idx_rd, dat_wr, dat_rd;
    assign in_pair = (bus_addr == IDX_A) || (bus_addr == DAT_A);
    assign idx_wr  = bus_wr && (bus_addr == IDX_A);
    assign idx_rd  = bus_rd && !bus_wr && (bus_addr == IDX_A);
    assign dat_wr  = bus_wr && (bus_addr == DAT_A);
    assign dat_rd  = bus_rd && !bus_wr && (bus_addr == DAT_A);

    assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !in_pair |=> $stable(idx_q) && $stable(regs_flat));

    assert_idx_legal_R2: assert property (@(posedge clk) disable iff (rst)
        (idx_q == '0) || idx_ok(idx_q));

    assert_idx_load_R2: assert property (@(posedge clk) disable iff (rst)
        idx_wr && idx_ok(bus_wdata) |=> idx_q == $past(bus_wdata));

    assert_idx_keep_R2: assert property (@(posedge clk) disable iff (rst)
        idx_wr && !idx_ok(bus_wdata) |=> $stable(idx_q));

    assert_idx_read_R3: assert property (@(posedge clk) disable iff (rst)
        idx_rd |=> bus_rdata == $past(idx_q));

    assert_wr_clears_R4: assert property (@(posedge clk) disable iff (rst)
        dat_wr && idx_ok(idx_q) |=> idx_q == '0);

    assert_rd_clears_R5: assert property (@(posedge clk) disable iff (rst)
        dat_rd && idx_ok(idx_q) |=> idx_q == '0);

    assert_bad_read_ff_R6: assert property (@(posedge clk) disable iff (rst)
        dat_rd && !idx_ok(idx_q) |=> bus_rdata == '1);

    assert_bad_write_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        dat_wr && !idx_ok(idx_q) |=> $stable(regs_flat) && $stable(idx_q));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && !bus_wr && in_pair) |=> $stable(bus_rdata));
endmodule

bind cfg_idx_port cfg_idx_port_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE_ADDR(BASE_ADDR),
    .LO_IDX   (LO_IDX),
    .HI_BASE  (HI_BASE),
    .HI_COUNT (HI_COUNT)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .idx_q    (idx_q),
    .regs_flat(regs_q)
);

// File: tb/cfg_idx_port_tb.sv
module cfg_idx_port_tb_top;
    localparam logic [15:0] IDX_P = 16'h0022;
    localparam logic [15:0] DAT_P = 16'h0023;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [7:0] m_idx;
    logic [7:0] m_reg [0:255];
    logic [7:0] rv;

    always #5 clk = ~clk;

    cfg_idx_port dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata)
    );

    function automatic bit m_valid(input int v);
        return (v == 1) || (v >= 'h70 && v <= 'h76);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    task automatic io_rdwr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        bus_rd    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++)
            m_reg[i] = (i == 'h01) ? 8'hC0 : (i == 'h71) ? 8'h01 : (i == 'h72) ? 8'hFF : 8'h00;
        m_idx     = 8'h00;
        rst       = 1'b1;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7: read data output after reset; R3: index after reset
        chk("R7 rdata reset", bus_rdata, 8'h00);
        io_rd(IDX_P, rv);
        chk("R3 index after reset", rv, 8'h00);

        // R7 defaults, R5 clear after read
        for (int i = 0; i < 256; i++) begin
            if (m_valid(i)) begin
                io_wr(IDX_P, 8'(i));
                io_rd(DAT_P, rv);
                chk($sformatf("R7 default idx %02h", i), rv, m_reg[i]);
                io_rd(IDX_P, rv);
                chk("R5 index cleared by read", rv, 8'h00);
            end
        end

        // R2 sweep of every index value
        m_idx = 8'h00;
        for (int v = 0; v < 256; v++) begin
            io_wr(IDX_P, 8'(v));
            if (m_valid(v)) m_idx = 8'(v);
            io_rd(IDX_P, rv);
            chk($sformatf("R2 index write %02h", v), rv, m_idx);
        end
        io_rd(IDX_P, rv);
        chk("R3 index read does not clear", rv, m_idx);
        io_rd(DAT_P, rv);
        chk("R5 read last index", rv, m_reg[m_idx]);
        m_idx = 8'h00;

        // R6 data access with nothing selected
        io_wr(DAT_P, 8'h5A);
        io_rd(DAT_P, rv);
        chk("R6 unselected read", rv, 8'hFF);
        io_rd(IDX_P, rv);
        chk("R6 index kept", rv, 8'h00);
        for (int i = 0; i < 256; i++) begin
            if (m_valid(i)) begin
                io_wr(IDX_P, 8'(i));
                io_rd(DAT_P, rv);
                chk($sformatf("R6 reg %02h untouched", i), rv, m_reg[i]);
            end
        end

        // R4/R5 write-back sweep
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < 256; i++) begin
                if (m_valid(i)) begin
                    logic [7:0] p;
                    p = 8'(i * 37 + j * 91 + 5);
                    io_wr(IDX_P, 8'(i));
                    io_wr(DAT_P, p);
                    m_reg[i] = p;
                    io_rd(IDX_P, rv);
                    chk("R4 index cleared by write", rv, 8'h00);
                    io_wr(IDX_P, 8'(i));
                    io_rd(DAT_P, rv);
                    chk($sformatf("R5 readback %02h", i), rv, p);
                end
            end
            for (int i = 0; i < 256; i++) begin
                if (m_valid(i)) begin
                    io_wr(IDX_P, 8'(i));
                    io_rd(DAT_P, rv);
                    chk($sformatf("R4 no crosstalk %02h", i), rv, m_reg[i]);
                end
            end
        end

        // R1 foreign addresses with a selection held
        io_wr(IDX_P, 8'h73);
        io_wr(16'h0020, 8'h75);
        io_wr(16'h0021, 8'hEE);
        io_wr(16'h0024, 8'h70);
        io_wr(16'h0025, 8'hEE);
        io_wr(16'h0122, 8'h01);
        io_wr(16'h0123, 8'hEE);
        io_wr(16'h8023, 8'hEE);
        io_rd(IDX_P, rv);
        chk("R1 index kept by foreign writes", rv, 8'h73);
        io_rd(16'h0123, rv);
        chk("R8 foreign read holds rdata", rv, 8'h73);
        io_rd(16'h0021, rv);
        chk("R1 foreign read holds rdata", rv, 8'h73);
        io_rd(DAT_P, rv);
        chk("R1 reg 73 not overwritten", rv, m_reg['h73]);

        // R9 simultaneous strobes
        io_wr(IDX_P, 8'h74);
        io_rd(IDX_P, rv);
        chk("R3 index readback", rv, 8'h74);
        io_rdwr(DAT_P, 8'h33);
        m_reg['h74] = 8'h33;
        @(negedge clk);
        chk("R9 rdata unchanged", bus_rdata, 8'h74);
        io_rd(IDX_P, rv);
        chk("R9 write consumed index", rv, 8'h00);
        io_wr(IDX_P, 8'h74);
        io_rd(DAT_P, rv);
        chk("R9 write stored", rv, 8'h33);

        // R8 hold across idle cycles
        repeat (4) @(negedge clk);
        chk("R8 rdata holds when idle", bus_rdata, 8'h33);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule